// File: doc/BRIEF.md
# Double-Trap Trap Controller

This block is the trap-control slice of a RISC-V hart that implements the machine-level and supervisor-level double-trap extensions. It holds one double-trap bit and one interrupt-enable bit for each of three trap levels: machine (M), hypervisor-extended supervisor (S) and virtual supervisor (VS). It also holds the two enables that switch the supervisor-level feature on, one for S and one for VS. When a trap request arrives, the block works out which level the trap would normally go to. It then decides whether the trap is a double trap. Finally it steers the trap to the M handler, the S handler, the VS handler or the resumable-NMI handler, or it reports a halt.

The surrounding core supplies the current privilege, the virtualization flag, the two delegation decisions for the trap, the resumable-NMI enable, one xRET strobe per level, and a write port for each status or envcfg field that this slice owns. The block returns the routing decision in the same cycle as the request. The state updates that the trap causes appear one cycle later. The block also returns a per-level interrupt-enable mask that already includes the double-trap and NMI gating.

Top module: `dbltrap_ctrl`

## Requirements
- R1: After reset, MDT equals parameter `MDT_RST_VAL` (default 1). Both SDT bits, both DTE bits and all three IE bits are 0.
- R2: The requested level of a trap is found in this order. It is M when the privilege input is M (2'b11) or when the S delegation input is 0. Otherwise it is VS when both the virtualization input and the VS delegation input are 1. Otherwise it is S. `tgt_o` is one-hot with bit 0 = M, bit 1 = S, bit 2 = VS and bit 3 = NMI. It is all zero when `trap_i` is 0.
- R3: A normal trap into a level clears that level's IE on the next cycle. A normal trap into M sets MDT. A normal trap into S or VS sets the matching SDT only when the matching DTE is 1.
- R4: A trap whose effective target is M while MDT is 1 and NMIE is 1 drives `tgt_o` = 4'b1000 and `dbl_o` = 1. It changes none of the held state.
- R5: A trap requested for S or VS while the matching SDT is 1 is redirected to M with `dbl_o` = 1. It is then handled as an M trap: it is a normal M trap if MDT is 0, and it follows R4 if MDT is 1.
- R6: When `nmie_i` is 0, every trap request raises `halt_o`, leaves `tgt_o` at zero and changes no held state.
- R7: `irq_en_o[k]` (k: 0 = M, 1 = S, 2 = VS) is 1 exactly when IE of level k is 1, DT of level k is 0 and `nmie_i` is 1.
- R8: While a DTE bit is 0, the matching SDT reads 0. A CSR write of 1 to that SDT is ignored. Writing 0 to a DTE bit clears the matching SDT.
- R9: A status write stores the written DT value, subject to R8. If the stored DT is 1, IE becomes 0 whatever IE value was written. Otherwise IE takes the written value.
- R10: An xRET strobe for level k clears DT of level k on the next cycle and leaves the DT bits of the other levels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| priv_i | input | 2 | Current privilege: 00 U, 01 S, 11 M |
| virt_i | input | 1 | Hart is in virtualized mode |
| deleg_hs_i | input | 1 | Trap is delegated away from M |
| deleg_vs_i | input | 1 | Trap is further delegated to VS |
| nmie_i | input | 1 | Resumable-NMI enable |
| trap_i | input | 1 | Trap request strobe |
| ret_i | input | 3 | xRET strobe per level: bit 0 M, bit 1 S, bit 2 VS |
| mst_we_i | input | 1 | M status write strobe |
| mst_mdt_i | input | 1 | Write data for MDT |
| mst_mie_i | input | 1 | Write data for MIE |
| sst_we_i | input | 1 | S status write strobe |
| sst_sdt_i | input | 1 | Write data for S SDT |
| sst_sie_i | input | 1 | Write data for S SIE |
| vsst_we_i | input | 1 | VS status write strobe |
| vsst_sdt_i | input | 1 | Write data for VS SDT |
| vsst_sie_i | input | 1 | Write data for VS SIE |
| menv_we_i | input | 1 | M envcfg write strobe |
| menv_dte_i | input | 1 | Write data for the S-level DTE |
| henv_we_i | input | 1 | H envcfg write strobe |
| henv_dte_i | input | 1 | Write data for the VS-level DTE |
| tgt_o | output | 4 | One-hot trap target {NMI, VS, S, M} |
| halt_o | output | 1 | Trap cannot be taken; hart must halt |
| dbl_o | output | 1 | Double-trap indication for the cause |
| mdt_o | output | 1 | MDT value |
| mie_o | output | 1 | MIE value |
| sdt_o | output | 1 | S SDT value |
| sie_o | output | 1 | S SIE value |
| vsdt_o | output | 1 | VS SDT value |
| vsie_o | output | 1 | VS SIE value |
| menv_dte_o | output | 1 | S-level DTE value |
| henv_dte_o | output | 1 | VS-level DTE value |
| irq_en_o | output | 3 | Gated interrupt enable per level {VS, S, M} |

## Verification
The assertions check the following on every cycle. The routing output stays one-hot and never overlaps a halt. An NMI target always carries the double-trap flag. Each normal trap sets the level's DT and clears its IE on the next cycle. xRET and DT=1 writes have their stated effect. SDT is never 1 while its DTE is 0. A halt leaves all held state frozen. Only the bench's sweep can show that the requested level is correct for each mix of privilege, virtualization and delegation. The sweep also shows that an S or VS double trap lands on M or NMI according to MDT, and that the gated interrupt mask matches the fields.

// File: rtl/dbltrap_pkg.sv
package dbltrap_pkg;
  localparam int unsigned PRIV_W  = 2;
  localparam int unsigned NUM_LVL = 3;
  localparam int unsigned TGT_W   = NUM_LVL + 1;

  localparam int unsigned LVL_M   = 0;
  localparam int unsigned LVL_S   = 1;
  localparam int unsigned LVL_VS  = 2;
  localparam int unsigned TGT_NMI = NUM_LVL;

  typedef enum logic [PRIV_W-1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;
endpackage

// File: rtl/dbltrap_route.sv
module dbltrap_route
  import dbltrap_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trap_i,
  input  logic [PRIV_W-1:0]  priv_i,
  input  logic               virt_i,
  input  logic               deleg_hs_i,
  input  logic               deleg_vs_i,
  input  logic               nmie_i,
  input  logic [NUM_LVL-1:0] dt_i,
  output logic [TGT_W-1:0]   tgt_o,
  output logic               halt_o,
  output logic               dbl_o,
  output logic [NUM_LVL-1:0] take_o
);

  logic [NUM_LVL-1:0] req;
  logic               redirect;
  logic               to_m;
  logic               m_dbl;

  // level the trap would reach without double-trap handling
  always_comb begin
    req = '0;
    if (priv_i == PRIV_M || !deleg_hs_i) req[LVL_M]  = 1'b1;
    else if (virt_i && deleg_vs_i)       req[LVL_VS] = 1'b1;
    else                                 req[LVL_S]  = 1'b1;
  end

  assign redirect = |(req[NUM_LVL-1:1] & dt_i[NUM_LVL-1:1]);
  assign to_m     = req[LVL_M] | redirect;
  assign m_dbl    = to_m & dt_i[LVL_M];

  always_comb begin
    tgt_o  = '0;
    halt_o = 1'b0;
    dbl_o  = 1'b0;
    take_o = '0;
    if (trap_i) begin
      if (!nmie_i) begin
        halt_o = 1'b1;
      end else if (m_dbl) begin
        tgt_o[TGT_NMI] = 1'b1;
        dbl_o          = 1'b1;
      end else if (to_m) begin
        tgt_o[LVL_M]  = 1'b1;
        take_o[LVL_M] = 1'b1;
        dbl_o         = redirect;
      end else begin
        tgt_o[NUM_LVL-1:0] = req;
        take_o             = req;
      end
    end
  end

  a_r2_tgt_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tgt_o) && !(halt_o && (|tgt_o)));

  a_r4_nmi_flags_dbl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_o[TGT_NMI] |-> dbl_o && (take_o == '0));

  a_r5_dbl_lands_m: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbl_o && !tgt_o[TGT_NMI] |-> tgt_o[LVL_M] && take_o[LVL_M]);

endmodule

// File: rtl/dbltrap_lvl.sv
module dbltrap_lvl #(
  parameter bit HAS_DTE = 1'b1,
  parameter bit DT_RST  = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic env_we_i,
  input  logic env_wd_i,
  input  logic take_i,
  input  logic ret_i,
  input  logic we_i,
  input  logic dt_wd_i,
  input  logic ie_wd_i,
  input  logic nmie_i,
  output logic dte_o,
  output logic dt_o,
  output logic ie_o,
  output logic irq_en_o
);

  logic dte_q;
  logic dt_q;
  logic ie_q;
  logic dt_eff_wd;

  if (HAS_DTE) begin : g_dte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       dte_q <= 1'b0;
      else if (env_we_i) dte_q <= env_wd_i;
    end
  end else begin : g_no_dte
    assign dte_q = 1'b1;
  end

  assign dt_eff_wd = dt_wd_i & dte_q;

  // priority: trap entry, then xRET, then CSR write; clearing DTE wins last
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dt_q <= DT_RST;
      ie_q <= 1'b0;
    end else begin
      if (take_i) begin
        dt_q <= dte_q;
        ie_q <= 1'b0;
      end else if (ret_i) begin
        dt_q <= 1'b0;
      end else if (we_i) begin
        dt_q <= dt_eff_wd;
        ie_q <= ie_wd_i & ~dt_eff_wd;
      end
      if (env_we_i && !env_wd_i) dt_q <= 1'b0;
    end
  end

  assign dte_o    = dte_q;
  assign dt_o     = dt_q;
  assign ie_o     = ie_q;
  assign irq_en_o = ie_q & ~dt_q & nmie_i;

  a_r3_take_sets_dt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !env_we_i |=> (dt_o == $past(dte_o)) && !ie_o);

  a_r10_ret_clears_dt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i && !take_i |=> !dt_o);

  a_r9_dt_write_clears_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !take_i && !ret_i && dt_wd_i && dte_o |=> !ie_o);

  a_r8_dt_needs_dte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dte_o |-> !dt_o);

endmodule

// File: rtl/dbltrap_ctrl.sv
module dbltrap_ctrl
  import dbltrap_pkg::*;
#(
  parameter bit MDT_RST_VAL = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRIV_W-1:0]  priv_i,
  input  logic               virt_i,
  input  logic               deleg_hs_i,
  input  logic               deleg_vs_i,
  input  logic               nmie_i,
  input  logic               trap_i,
  input  logic [NUM_LVL-1:0] ret_i,
  input  logic               mst_we_i,
  input  logic               mst_mdt_i,
  input  logic               mst_mie_i,
  input  logic               sst_we_i,
  input  logic               sst_sdt_i,
  input  logic               sst_sie_i,
  input  logic               vsst_we_i,
  input  logic               vsst_sdt_i,
  input  logic               vsst_sie_i,
  input  logic               menv_we_i,
  input  logic               menv_dte_i,
  input  logic               henv_we_i,
  input  logic               henv_dte_i,
  output logic [TGT_W-1:0]   tgt_o,
  output logic               halt_o,
  output logic               dbl_o,
  output logic               mdt_o,
  output logic               mie_o,
  output logic               sdt_o,
  output logic               sie_o,
  output logic               vsdt_o,
  output logic               vsie_o,
  output logic               menv_dte_o,
  output logic               henv_dte_o,
  output logic [NUM_LVL-1:0] irq_en_o
);

  localparam bit [NUM_LVL-1:0] HAS_DTE_V = 3'b110;
  localparam bit [NUM_LVL-1:0] DT_RST_V  = {2'b00, MDT_RST_VAL};

  logic [NUM_LVL-1:0] dt, ie, dte, take;
  logic [NUM_LVL-1:0] we, dt_wd, ie_wd, env_we, env_wd;

  assign we     = {vsst_we_i,  sst_we_i,  mst_we_i};
  assign dt_wd  = {vsst_sdt_i, sst_sdt_i, mst_mdt_i};
  assign ie_wd  = {vsst_sie_i, sst_sie_i, mst_mie_i};
  assign env_we = {henv_we_i,  menv_we_i,  1'b0};
  assign env_wd = {henv_dte_i, menv_dte_i, 1'b0};

  dbltrap_route u_route (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trap_i     (trap_i),
    .priv_i     (priv_i),
    .virt_i     (virt_i),
    .deleg_hs_i (deleg_hs_i),
    .deleg_vs_i (deleg_vs_i),
    .nmie_i     (nmie_i),
    .dt_i       (dt),
    .tgt_o      (tgt_o),
    .halt_o     (halt_o),
    .dbl_o      (dbl_o),
    .take_o     (take)
  );

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    dbltrap_lvl #(
      .HAS_DTE (HAS_DTE_V[g]),
      .DT_RST  (DT_RST_V[g])
    ) u_lvl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .env_we_i (env_we[g]),
      .env_wd_i (env_wd[g]),
      .take_i   (take[g]),
      .ret_i    (ret_i[g]),
      .we_i     (we[g]),
      .dt_wd_i  (dt_wd[g]),
      .ie_wd_i  (ie_wd[g]),
      .nmie_i   (nmie_i),
      .dte_o    (dte[g]),
      .dt_o     (dt[g]),
      .ie_o     (ie[g]),
      .irq_en_o (irq_en_o[g])
    );
  end

  assign mdt_o      = dt[LVL_M];
  assign mie_o      = ie[LVL_M];
  assign sdt_o      = dt[LVL_S];
  assign sie_o      = ie[LVL_S];
  assign vsdt_o     = dt[LVL_VS];
  assign vsie_o     = ie[LVL_VS];
  assign menv_dte_o = dte[LVL_S];
  assign henv_dte_o = dte[LVL_VS];

  a_r6_halt_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o && !(|we) && !(|ret_i) && !(|env_we) |=> $stable({dt, ie, dte}));

endmodule

// File: tb/tb_dbltrap_ctrl.sv
`timescale 1ns/1ps
module tb_dbltrap_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] priv;
  logic       virt, dhs, dvs, nmie, trap;
  logic [2:0] ret;
  logic       mst_we, mst_mdt, mst_mie, sst_we, sst_sdt, sst_sie;
  logic       vsst_we, vsst_sdt, vsst_sie, menv_we, menv_dte, henv_we, henv_dte;
  logic [3:0] tgt;
  logic       halt, dbl, mdt, mie, sdt, sie, vsdt, vsie, mdte, hdte;
  logic [2:0] irq_en;

  int n_vec = 0;
  int n_bad = 0;

  // bench model of held state
  bit e_mdt, e_mie, e_sdt, e_sie, e_vdt, e_vie, e_dtes, e_dtev;

  always #10 clk = ~clk;

  dbltrap_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .priv_i(priv), .virt_i(virt),
    .deleg_hs_i(dhs), .deleg_vs_i(dvs), .nmie_i(nmie), .trap_i(trap), .ret_i(ret),
    .mst_we_i(mst_we), .mst_mdt_i(mst_mdt), .mst_mie_i(mst_mie),
    .sst_we_i(sst_we), .sst_sdt_i(sst_sdt), .sst_sie_i(sst_sie),
    .vsst_we_i(vsst_we), .vsst_sdt_i(vsst_sdt), .vsst_sie_i(vsst_sie),
    .menv_we_i(menv_we), .menv_dte_i(menv_dte), .henv_we_i(henv_we), .henv_dte_i(henv_dte),
    .tgt_o(tgt), .halt_o(halt), .dbl_o(dbl), .mdt_o(mdt), .mie_o(mie),
    .sdt_o(sdt), .sie_o(sie), .vsdt_o(vsdt), .vsie_o(vsie),
    .menv_dte_o(mdte), .henv_dte_o(hdte), .irq_en_o(irq_en)
  );

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic chk_state(input string rq);
    chk(rq, {mdt, mie, sdt, sie, vsdt, vsie, mdte, hdte},
            {e_mdt, e_mie, e_sdt, e_sie, e_vdt, e_vie, e_dtes, e_dtev});
  endtask

  task automatic idle();
    trap = 0; ret = '0;
    mst_we = 0; sst_we = 0; vsst_we = 0; menv_we = 0; henv_we = 0;
    mst_mdt = 0; mst_mie = 0; sst_sdt = 0; sst_sie = 0;
    vsst_sdt = 0; vsst_sie = 0; menv_dte = 0; henv_dte = 0;
  endtask

  // set DTEs, then DT bits with IE written as 1
  task automatic setup(input bit m, input bit ds, input bit s, input bit dv, input bit v);
    @(negedge clk);
    menv_we = 1; menv_dte = ds; henv_we = 1; henv_dte = dv;
    @(negedge clk);
    idle();
    mst_we = 1; mst_mdt = m; mst_mie = 1;
    sst_we = 1; sst_sdt = s; sst_sie = 1;
    vsst_we = 1; vsst_sdt = v; vsst_sie = 1;
    @(negedge clk);
    idle();
    e_dtes = ds; e_dtev = dv;
    e_mdt = m;       e_mie = !m;
    e_sdt = s & ds;  e_sie = !(s & ds);
    e_vdt = v & dv;  e_vie = !(v & dv);
    chk_state((s && !ds) || (v && !dv) ? "R8" : "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    priv = 2'b00; virt = 0; dhs = 0; dvs = 0; nmie = 1;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {mdt, mie, sdt, sie, vsdt, vsie, mdte, hdte}, 8'b1000_0000);
    chk("R1", {5'b0, irq_en}, 8'h00);
    chk("R2", {4'b0, tgt}, 8'h00);

    // main sweep: held state x privilege x virt x delegation x NMIE
    for (int st = 0; st < 32; st++) begin
      for (int p = 0; p < 3; p++) begin
        for (int c = 0; c < 16; c++) begin
          bit [1:0] pv;
          int req;
          bit redir, tom, x_halt, x_dbl;
          bit [3:0] x_tgt;
          string rq;
          pv = (p == 0) ? 2'b00 : (p == 1) ? 2'b01 : 2'b11;
          setup(st[0], st[1], st[2], st[3], st[4]);
          priv = pv; virt = c[0]; dhs = c[1]; dvs = c[2]; nmie = c[3];
          #2;
          // R7 gated interrupt mask, with R6 zeroing when NMIE=0
          chk("R7", {5'b0, irq_en},
              {5'b0, e_vie & !e_vdt & nmie, e_sie & !e_sdt & nmie, e_mie & !e_mdt & nmie});
          trap = 1;
          if (pv == 2'b11 || !dhs) req = 0;
          else if (virt && dvs)    req = 2;
          else                     req = 1;
          redir = (req == 1 && e_sdt) || (req == 2 && e_vdt);
          tom = (req == 0) || redir;
          x_halt = 0; x_dbl = 0; x_tgt = 4'b0;
          if (!nmie) begin
            x_halt = 1; rq = "R6";
          end else if (tom && e_mdt) begin
            x_tgt = 4'b1000; x_dbl = 1; rq = "R4";
          end else if (tom) begin
            x_tgt = 4'b0001; x_dbl = redir; rq = redir ? "R5" : "R2";
            e_mdt = 1; e_mie = 0;
          end else if (req == 1) begin
            x_tgt = 4'b0010; rq = "R2";
            e_sdt = e_dtes; e_sie = 0;
          end else begin
            x_tgt = 4'b0100; rq = "R2";
            e_vdt = e_dtev; e_vie = 0;
          end
          #5;
          chk(rq, {2'b0, x_halt, x_dbl, tgt}, {2'b0, halt, dbl, x_tgt});
          @(negedge clk);
          trap = 0;
          chk((x_halt || x_tgt[3]) ? (x_halt ? "R6" : "R4") : "R3", 8'h00, 8'h00);
          chk_state((x_halt) ? "R6" : (x_tgt[3] ? "R4" : "R3"));
        end
      end
    end

    // R10: each xRET clears only its own level
    nmie = 1;
    for (int k = 0; k < 3; k++) begin
      setup(1, 1, 1, 1, 1);
      ret[k] = 1'b1;
      @(negedge clk);
      ret = '0;
      if (k == 0) e_mdt = 0;
      if (k == 1) e_sdt = 0;
      if (k == 2) e_vdt = 0;
      chk_state("R10");
    end

    // R8: clearing DTE clears SDT; SDT write ignored while DTE is 0
    setup(0, 1, 1, 1, 1);
    menv_we = 1; menv_dte = 0;
    @(negedge clk);
    idle();
    e_dtes = 0; e_sdt = 0;
    chk_state("R8");
    sst_we = 1; sst_sdt = 1; sst_sie = 1;
    @(negedge clk);
    idle();
    e_sie = 1;
    chk_state("R8");
    chk("R7", {5'b0, irq_en}, {5'b0, 1'b0, 1'b1, 1'b1});

    // R9: DT written 0 takes IE as written; DT written 1 forces IE to 0
    mst_we = 1; mst_mdt = 1; mst_mie = 1;
    @(negedge clk);
    idle();
    chk("R9", {6'b0, mdt, mie}, 8'b10);
    mst_we = 1; mst_mdt = 0; mst_mie = 1;
    @(negedge clk);
    idle();
    chk("R9", {6'b0, mdt, mie}, 8'b01);
    mst_we = 1; mst_mdt = 0; mst_mie = 0;
    @(negedge clk);
    idle();
    chk("R9", {6'b0, mdt, mie}, 8'b00);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule